// File: doc/BRIEF.md
# Seconds Counter with Alarm Interrupt

This block is a real-time-clock peripheral that sits on a simple 32-bit register bus. It holds a free-running seconds count that steps by one whenever a one-per-second tick-enable pulse is high. Software can set the count by writing a load value, and can program a match value that raises an alarm interrupt when the count reaches it. The tick itself comes from a prescaler outside the block. Clock-domain crossing and calendar conversion also happen outside the block.

The interrupt path has three parts: a sticky raw status bit, a one-bit enable mask, and a write-to-clear location. The interrupt line is the raw bit gated by the mask. A small read-only identification window returns fixed bytes. The bus is synchronous: a write takes effect at the clock edge where it is presented, and read data is registered one cycle after the read strobe.

Word offsets, all addressed by byte:

| Offset | Access | Contents |
|--------|--------|----------|
| 0x00 | read-only | current count |
| 0x04 | read/write | match value |
| 0x08 | read/write | load value |
| 0x0C | read/write | control, which always reads 1 |
| 0x10 | read/write | mask, bit 0 only |
| 0x14 | read-only | raw status, bit 0 |
| 0x18 | read-only | masked status, bit 0 |
| 0x1C | write-only | clear |
| 0xFE0 to 0xFFC | read-only | identification bytes |

Top module: `secs_alarm_rtc`

## Requirements
- R1: After a synchronous active-low reset, the count, match, load value, mask and raw status are all zero. The interrupt line and the read data are also zero.
- R2: On each clock edge where `tick_en` is high and no load write is presented, the count increments by one, and it wraps from 0xFFFFFFFF to 0. Without a tick the count holds.
- R3: A write to offset 0x08 sets the count to the written data at that edge, overriding a tick in the same cycle. Reading 0x08 returns the last value written there.
- R4: The match register at 0x04 reads back what was written. When a tick brings the count equal to the match value, raw status (offset 0x14, bit 0) reads 1 from that same updated cycle on.
- R5: A write to 0x04 or 0x08 that leaves the count equal to the match value sets raw status at once, in the same edge.
- R6: Matching uses the wrapping 32-bit count, so a match value below the current count fires only after the count passes 0xFFFFFFFF.
- R7: Only bit 0 of a write to the mask at 0x10 is kept. `alarm_irq` equals raw status AND mask. Offset 0x18 reads the same value in bit 0.
- R8: Any write to 0x1C clears raw status, whatever the data. If an alarm set event and a clear write happen in the same cycle, raw status ends up set. Raw status does not set again while the count merely stays equal to the match value.
- R9: The control register at 0x0C always reads 1, and writes to it change nothing.
- R10: Reads of 0xFE0, 0xFE4, ... 0xFFC return 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, in bits 7:0, with all upper bits zero.
- R11: Reads of 0x1C or of unmapped offsets return 0. Writes to 0x00, 0x14, 0x18, the identification window or unmapped offsets change no readable state.
- R12: `bus_rdata` changes only in the cycle after `bus_rd` is high, and then it shows the register state from before any write presented in the same cycle. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| tick_en | input | 1 | one-per-second count enable |
| bus_addr | input | ADDR_W | byte address, bits 1:0 ignored |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | registered read data |
| alarm_irq | output | 1 | masked alarm interrupt |

## Verification
The bench builds the block with its default widths: a 32-bit data path and a 12-bit address. The 12-bit address covers the whole register page, including the identification window at the top. Because the count can be loaded to 0xFFFFFFFE, the wrap past zero and the late firing of a low match value are reached in a few ticks. Simultaneous tick-with-load and tick-with-clear cycles are driven on purpose to exercise the two priority rules.

// File: rtl/rtc_pkg.sv
// Package: shared register offsets and identification bytes for the
// seconds-counter RTC. Assumes a 4 KiB register page with word-aligned
// accesses.
package rtc_pkg;
    localparam int PAGE_AW = 12;

    localparam logic [PAGE_AW-1:0] OFS_COUNT = 12'h000;
    localparam logic [PAGE_AW-1:0] OFS_MATCH = 12'h004;
    localparam logic [PAGE_AW-1:0] OFS_LOAD  = 12'h008;
    localparam logic [PAGE_AW-1:0] OFS_CTRL  = 12'h00C;
    localparam logic [PAGE_AW-1:0] OFS_MASK  = 12'h010;
    localparam logic [PAGE_AW-1:0] OFS_RAW   = 12'h014;
    localparam logic [PAGE_AW-1:0] OFS_MSTAT = 12'h018;
    localparam logic [PAGE_AW-1:0] OFS_CLEAR = 12'h01C;
    localparam logic [PAGE_AW-1:0] OFS_IDWIN = 12'hFE0;

    // Identification byte for word index 0..7 of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/rtc_count_unit.sv
// Seconds count and load-value holder.
// Does: steps the count on tick_en, or replaces it on a load write (the load
// wins). Exposes the next count value and a flag saying the count is being
// updated, so the alarm logic can compare in the same edge.
// Assumes: the load strobe is already decoded.
module rtc_count_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] cnt_nxt,
    output logic              cnt_upd,
    output logic [DATA_W-1:0] load_q
);
    // Next-count selection: a load overrides a tick.
    always_comb begin
        cnt_upd = load_wr | tick_en;
        if (load_wr)
            cnt_nxt = load_val;
        else if (tick_en)
            cnt_nxt = cnt_q + DATA_W'(1);
        else
            cnt_nxt = cnt_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // Holds the last written load value for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (load_wr) load_q <= load_val;
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
// Match register, raw alarm status, mask and interrupt output.
// Does: sets raw status when an update of the count or of the match value
// makes the two equal. A clear write drops raw status unless a set event
// happens in the same edge.
// Assumes: strobes are decoded and at most one register write per cycle.
module rtc_alarm_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_wr,
    input  logic              mask_wr,
    input  logic              clear_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_nxt,
    input  logic              cnt_upd,
    output logic [DATA_W-1:0] match_q,
    output logic              mask_q,
    output logic              raw_q,
    output logic              irq
);
    logic [DATA_W-1:0] match_nxt;
    logic              set_evt;

    // Event detection on the post-edge values.
    always_comb begin
        match_nxt = match_wr ? wdata : match_q;
        set_evt   = (cnt_upd | match_wr) && (cnt_nxt == match_nxt);
    end

    // Match value register.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= match_nxt;
    end

    // One-bit mask; upper write bits are discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (mask_wr) mask_q <= wdata[0];
    end

    // Sticky raw status; a set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw_q <= 1'b0;
        else if (set_evt)  raw_q <= 1'b1;
        else if (clear_wr) raw_q <= 1'b0;
    end

    // Interrupt line gated by the mask.
    assign irq = raw_q & mask_q;
endmodule

// File: rtl/rtc_bus_port.sv
// Register bus front end.
// Does: decodes write strobes from the address and registers the read data
// one cycle after the read strobe. The read data holds when there is no read.
// Assumes: ADDR_W is at least 12; address bits 1:0 are ignored.
module rtc_bus_port #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic [DATA_W-1:0] match_q,
    input  logic [DATA_W-1:0] load_q,
    input  logic              mask_q,
    input  logic              raw_q,
    output logic              load_wr,
    output logic              match_wr,
    output logic              mask_wr,
    output logic              clear_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    import rtc_pkg::*;

    localparam int LOW_IGN = 2;
    localparam int ID_IGN  = 5;

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] id_base;
    logic              id_hit;
    logic [DATA_W-1:0] rd_mux;

    // Aligned address, ID-window hit, and the decoded write strobes.
    always_comb begin
        word_addr = {bus_addr[ADDR_W-1:LOW_IGN], {LOW_IGN{1'b0}}};
        id_base   = {bus_addr[ADDR_W-1:ID_IGN], {ID_IGN{1'b0}}};
        id_hit    = (id_base == ADDR_W'(OFS_IDWIN));
        load_wr   = bus_wr && (word_addr == ADDR_W'(OFS_LOAD));
        match_wr  = bus_wr && (word_addr == ADDR_W'(OFS_MATCH));
        mask_wr   = bus_wr && (word_addr == ADDR_W'(OFS_MASK));
        clear_wr  = bus_wr && (word_addr == ADDR_W'(OFS_CLEAR));
    end

    // Read multiplexer; the clear register and holes read zero.
    always_comb begin
        rd_mux = '0;
        if (id_hit)
            rd_mux = DATA_W'(id_byte(bus_addr[4:2]));
        else if (word_addr == ADDR_W'(OFS_COUNT)) rd_mux = cnt_q;
        else if (word_addr == ADDR_W'(OFS_MATCH)) rd_mux = match_q;
        else if (word_addr == ADDR_W'(OFS_LOAD))  rd_mux = load_q;
        else if (word_addr == ADDR_W'(OFS_CTRL))  rd_mux = DATA_W'(1);
        else if (word_addr == ADDR_W'(OFS_MASK))  rd_mux = DATA_W'(mask_q);
        else if (word_addr == ADDR_W'(OFS_RAW))   rd_mux = DATA_W'(raw_q);
        else if (word_addr == ADDR_W'(OFS_MSTAT)) rd_mux = DATA_W'(raw_q & mask_q);
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/secs_alarm_rtc.sv
// Top of the seconds-counter RTC with alarm interrupt.
// Does: ties the bus front end, the count unit and the alarm unit together.
// Assumes: tick_en is synchronous to clk and at most one cycle per second
// wide; the bus issues at most one access per cycle.
module secs_alarm_rtc #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    logic [DATA_W-1:0] cnt_q, cnt_nxt, load_q, match_q;
    logic              cnt_upd, mask_q, raw_q;
    logic              load_wr, match_wr, mask_wr, clear_wr;

    rtc_bus_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .cnt_q(cnt_q), .match_q(match_q), .load_q(load_q),
        .mask_q(mask_q), .raw_q(raw_q), .load_wr(load_wr),
        .match_wr(match_wr), .mask_wr(mask_wr), .clear_wr(clear_wr),
        .bus_rdata(bus_rdata)
    );

    rtc_count_unit #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_wr(load_wr),
        .load_val(bus_wdata), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
        .cnt_upd(cnt_upd), .load_q(load_q)
    );

    rtc_alarm_unit #(.DATA_W(DATA_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .match_wr(match_wr), .mask_wr(mask_wr),
        .clear_wr(clear_wr), .wdata(bus_wdata), .cnt_nxt(cnt_nxt),
        .cnt_upd(cnt_upd), .match_q(match_q), .mask_q(mask_q),
        .raw_q(raw_q), .irq(alarm_irq)
    );
endmodule

// File: rtl/secs_alarm_rtc_chk.sv
// Property checker for secs_alarm_rtc, attached with bind.
// Does: decodes the bus itself and checks count, alarm and read-port rules.
// Assumes: the same register offsets as rtc_pkg.
module secs_alarm_rtc_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              alarm_irq,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] match_q,
    input logic              mask_q,
    input logic              raw_q
);
    import rtc_pkg::*;

    logic [ADDR_W-1:0] wa;
    logic              c_load, c_clear, c_ctrl_rd;

    // Independent decode of the bus strobes.
    always_comb begin
        wa        = {bus_addr[ADDR_W-1:2], 2'b00};
        c_load    = bus_wr && (wa == ADDR_W'(OFS_LOAD));
        c_clear   = bus_wr && (wa == ADDR_W'(OFS_CLEAR));
        c_ctrl_rd = bus_rd && (wa == ADDR_W'(OFS_CTRL));
    end

    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !c_load) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !c_load) |=> $stable(cnt_q));

    p_load_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_load |=> (cnt_q == $past(bus_wdata)));

    p_raw_rise_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> (cnt_q == match_q));

    p_load_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_load && (bus_wdata == match_q)) |=> raw_q);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !alarm_irq);

    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_clear && !tick_en) |=> !raw_q);

    p_ctrl_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_ctrl_rd |=> (bus_rdata == DATA_W'(1)));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind secs_alarm_rtc secs_alarm_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .alarm_irq(alarm_irq), .cnt_q(cnt_q),
    .match_q(match_q), .mask_q(mask_q), .raw_q(raw_q)
);

// File: tb/sim_secs_alarm_rtc.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module sim_secs_alarm_rtc;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam time T_CLK = 10ns;

    localparam logic [AW-1:0] A_CNT = 12'h000, A_MAT = 12'h004,
        A_LD = 12'h008, A_CTL = 12'h00C, A_MSK = 12'h010, A_RAW = 12'h014,
        A_MST = 12'h018, A_CLR = 12'h01C, A_ID = 12'hFE0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          alarm_irq;

    int checks = 0;
    int errors = 0;
    logic          rd_seen = 1'b0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] last_exp = '0;

    secs_alarm_rtc #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    always #(T_CLK/2) clk = ~clk;

    // Tracks which edges captured a read strobe.
    always @(posedge clk) rd_seen <= bus_rd && rst_n;

    // Monitor: pops one expected item for every completed read.
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [DW-1:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12: read data %h with empty scoreboard", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic tk = 1'b0);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e,
                            input string t);
        exp_q.push_back(e); tag_q.push_back(t); last_exp = e;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_pin(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: alarm_irq actual %b expected %b", t, act, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state at the pins
        chk_pin(alarm_irq, 1'b0, "R1");
        checks++;
        if (bus_rdata !== '0) begin
            errors++;
            $display("FAIL R1: rdata actual %h expected 0", bus_rdata);
        end
        rst_n = 1'b1;
        idle(1);
        bus_read(A_CNT, 32'h0, "R1");
        bus_read(A_MAT, 32'h0, "R1");
        bus_read(A_LD,  32'h0, "R1");
        bus_read(A_MSK, 32'h0, "R1");
        bus_read(A_RAW, 32'h0, "R1");

        // R2: tick stepping and holding
        ticks(5);
        bus_read(A_CNT, 32'd5, "R2");
        idle(3);
        bus_read(A_CNT, 32'd5, "R2");

        // R3: load sets the count, wins over a tick, reads back
        bus_write(A_LD, 32'h1234_0000);
        bus_read(A_CNT, 32'h1234_0000, "R3");
        bus_write(A_LD, 32'h100, 1'b1);
        bus_read(A_CNT, 32'h100, "R3");
        bus_read(A_LD,  32'h100, "R3");

        // R4: match readback and firing on the tick that reaches it
        bus_write(A_MAT, 32'h105);
        bus_read(A_MAT, 32'h105, "R4");
        ticks(4);
        bus_read(A_RAW, 32'h0, "R4");
        ticks(1);
        bus_read(A_RAW, 32'h1, "R4");

        // R7: mask keeps bit 0 only; irq and masked status follow
        chk_pin(alarm_irq, 1'b0, "R7");
        bus_read(A_MST, 32'h0, "R7");
        bus_write(A_MSK, 32'hFFFF_FFFE);
        bus_read(A_MSK, 32'h0, "R7");
        bus_write(A_MSK, 32'h3);
        bus_read(A_MSK, 32'h1, "R7");
        chk_pin(alarm_irq, 1'b1, "R7");
        bus_read(A_MST, 32'h1, "R7");

        // R8: clear with any data, no re-fire, set beats clear
        bus_write(A_CLR, 32'h0);
        chk_pin(alarm_irq, 1'b0, "R8");
        idle(2);
        bus_read(A_RAW, 32'h0, "R8");
        bus_write(A_LD, 32'h200);
        bus_write(A_MAT, 32'h201);
        bus_read(A_RAW, 32'h0, "R8");
        bus_write(A_CLR, 32'h0, 1'b1);
        bus_read(A_RAW, 32'h1, "R8");
        bus_write(A_CLR, 32'hFFFF_FFFF);
        bus_read(A_RAW, 32'h0, "R8");

        // R5: immediate firing on match write and on load write
        bus_write(A_MAT, 32'h201);
        bus_read(A_RAW, 32'h1, "R5");
        bus_write(A_CLR, 32'h1);
        bus_write(A_MAT, 32'h5000);
        bus_read(A_RAW, 32'h0, "R5");
        bus_write(A_LD, 32'h5000);
        chk_pin(alarm_irq, 1'b1, "R5");
        bus_read(A_RAW, 32'h1, "R5");
        bus_write(A_CLR, 32'h1);

        // R6: a match below the count fires only after the wrap
        bus_write(A_MAT, 32'h1);
        bus_write(A_LD, 32'hFFFF_FFFE);
        ticks(2);
        bus_read(A_RAW, 32'h0, "R6");
        bus_read(A_CNT, 32'h0, "R2");
        ticks(1);
        bus_read(A_RAW, 32'h1, "R6");
        bus_write(A_CLR, 32'h0);

        // R9: control is constant
        bus_read(A_CTL, 32'h1, "R9");
        bus_write(A_CTL, 32'h0);
        bus_read(A_CTL, 32'h1, "R9");
        bus_read(A_CNT, 32'h1, "R9");

        // R10: identification window
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            case (i)
                0: b = 8'h31; 1: b = 8'h10; 2: b = 8'h14; 3: b = 8'h00;
                4: b = 8'h0D; 5: b = 8'hF0; 6: b = 8'h05; default: b = 8'hB1;
            endcase
            bus_read(A_ID + AW'(4*i), {24'h0, b}, "R10");
        end

        // R11: zero reads and ignored writes
        bus_read(A_CLR, 32'h0, "R11");
        bus_read(12'h020, 32'h0, "R11");
        bus_read(12'hFC0, 32'h0, "R11");
        bus_write(A_CNT, 32'hDEAD);
        bus_read(A_CNT, 32'h1, "R11");
        bus_write(A_RAW, 32'h1);
        bus_write(A_MST, 32'h1);
        bus_read(A_RAW, 32'h0, "R11");
        bus_write(12'h040, 32'h77);
        bus_write(A_ID, 32'h99);
        bus_read(A_MAT, 32'h1, "R11");
        bus_read(A_LD, 32'hFFFF_FFFE, "R11");
        bus_read(A_ID, 32'h31, "R11");

        // R12: read data holds without a strobe; a read sees pre-write state
        idle(3);
        checks++;
        if (bus_rdata !== last_exp) begin
            errors++;
            $display("FAIL R12: rdata actual %h expected %h", bus_rdata, last_exp);
        end
        exp_q.push_back(32'hFFFF_FFFE); tag_q.push_back("R12");
        bus_addr = A_LD; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h42;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        bus_read(A_LD, 32'h42, "R12");

        idle(2);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule